// File: doc/BRIEF.md
# MDIO management bus controller

This block is the host side of the serial management bus that connects an Ethernet MAC to its PHY. Software talks to it through a small synchronous register port. It configures a clock divider, loads a PHY address and a register number, and then starts a transfer. A write starts when the write-data register is written. A read starts when the read bit of the command register changes from 0 to 1. While a frame is in flight a busy flag is set. When busy clears after a read, the captured 16-bit value can be read back.

The block derives the management clock from the system clock by a fixed divider. The divider is picked from the set 4, 6, 8, 10, 14, 20 and 28. The data line is split into an output, an output enable and an input, so that a pad cell outside the block can form the bidirectional wire. After reset, the divider select holds the smallest table entry that brings the management clock down to the allowed maximum for the configured system clock. Software may overwrite it.

Top module: `mdio_host`

## Requirements
- R1: After reset the status register reads 0 (bit 0 is busy), `mdc` is 0, `mdio_oe` is 0 and the read-data register reads 0.
- R2: The configuration register sits at offset 0, with bit 15 as the management reset and bits [2:0] as the divider select. Select codes 0..6 choose dividers 4, 6, 8, 10, 14, 20 and 28, and code 7 chooses 28. The select resets to the smallest entry that is at least floor(SYS_CLK_HZ / MDC_MAX_HZ), or to code 6 when no entry is large enough. The management reset bit resets to 0.
- R3: While a frame runs, `mdc` has a period equal to the selected divider in system clocks. Its high phase and its low phase each last half of that divider.
- R4: A write to the write-data register (offset 2) while idle and out of management reset starts a write frame. The frame is driven MSB first with `mdio_oe` high for all of it: PRE_LEN ones, 01, opcode 01, the 5-bit PHY address, the 5-bit register number, 10, and the 16 data bits. The address register at offset 1 holds the PHY address in [12:8] and the register number in [4:0].
- R5: Changing bit 0 of the command register (offset 3) from 0 to 1 while idle starts a read frame. This frame has opcode 10 and drives PRE_LEN+14 bits. `mdio_oe` is then low from the turnaround to the end of the frame. The 16 data bits are sampled MSB first at the rising edges of `mdc` and appear at the read-data register (offset 4) once busy clears.
- R6: Busy reads 1 in the cycle after the starting register write and stays 1 until the frame ends. A read bit that is held at 1 starts no further frame. Software clears it before the next read.
- R7: `mdio_o` and `mdio_oe` change only while `mdc` is low.
- R8: While the management reset bit is set, busy is 0 and no frame starts. Setting the bit during a frame brings busy, `mdc` and `mdio_oe` to 0 by the second clock edge after the write.
- R9: While busy, writes to the write-data and command registers are ignored. Their contents stay unchanged and no further frame follows.
- R10: The read-data register ignores writes. The status register is at offset 5. Bits of any register that are not assigned read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the addressed register |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | Management data line, input side |
| mdio_o | output | 1 | Management data line, output value |
| mdio_oe | output | 1 | Management data line, output enable |

## Verification
The bench builds the block with a 125 MHz system clock and an 11 MHz maximum management clock. The quotient 11 then falls between table entries, so the reset select must round up to the divider 14 and not simply match an entry. The full 32-bit preamble is kept, which makes every frame exactly 64 bit slots long. A bench PHY model can therefore capture whole frames and answer reads. Over the run, software rewrites all eight select codes, including the two ends of the table and the duplicate code 7.

// File: rtl/mdio_host_pkg.sv
package mdio_host_pkg;
   localparam int DSEL_W = 3;
   localparam int DATA_W = 16;
   localparam int PHY_W  = 5;
   localparam int REGN_W = 5;
   localparam int DIVC_W = 5;

   localparam logic [1:0] OP_WR = 2'b01;
   localparam logic [1:0] OP_RD = 2'b10;

   // divider in system clocks for each select code
   function automatic logic [DIVC_W-1:0] div_of(input logic [DSEL_W-1:0] s);
      case (s)
         3'd0:    return 5'd4;
         3'd1:    return 5'd6;
         3'd2:    return 5'd8;
         3'd3:    return 5'd10;
         3'd4:    return 5'd14;
         3'd5:    return 5'd20;
         default: return 5'd28;
      endcase
   endfunction

   // smallest entry not below the clock ratio, else the slowest one
   function automatic logic [DSEL_W-1:0] pick_sel(input int ratio);
      for (int i = 0; i < 7; i++) begin
         if (int'(div_of(i[DSEL_W-1:0])) >= ratio) return i[DSEL_W-1:0];
      end
      return 3'd6;
   endfunction
endpackage

// File: rtl/mdio_host_clk.sv
module mdio_host_clk #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] div,
   output logic             tick_low,
   output logic             tick_rise,
   output logic             mdc
);
   logic [CNT_W-1:0] cnt, cnt_nxt, half;

   assign half = div >> 1;

   always_comb begin
      if (!run)                        cnt_nxt = '0;
      else if (cnt == div - 1'b1)      cnt_nxt = '0;
      else                             cnt_nxt = cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else begin
         cnt <= cnt_nxt;
         mdc <= run && (cnt_nxt >= half);
      end
   end

   assign tick_low  = run && (cnt == '0);
   assign tick_rise = run && (cnt == half - 1'b1);

   // low-phase length monitor for the checks below
   logic [CNT_W-1:0] lo_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             lo_cnt <= '0;
      else if (!run || mdc)   lo_cnt <= '0;
      else                    lo_cnt <= lo_cnt + 1'b1;
   end

   a_r3_low_half: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mdc) |-> (lo_cnt == half));
   a_r3_div_legal: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (div >= 4));
endmodule

// File: rtl/mdio_host_eng.sv
module mdio_host_eng
   import mdio_host_pkg::*;
#(
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort,
   input  logic              start,
   input  logic              op_rd,
   input  logic [PHY_W-1:0]  phy,
   input  logic [REGN_W-1:0] regn,
   input  logic [DATA_W-1:0] wdata,
   input  logic              tick_low,
   input  logic              tick_rise,
   input  logic              mdio_i,
   output logic              busy,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [DATA_W-1:0] rdata
);
   localparam int FRAME_LEN = PRE_LEN + 32;
   localparam int DRIVE_LEN = PRE_LEN + 14;
   localparam int SAMP_FROM = FRAME_LEN - DATA_W;
   localparam int IDX_W     = $clog2(FRAME_LEN + 1);

   logic [FRAME_LEN-1:0] frame_sh;
   logic [IDX_W-1:0]     idx;
   logic                 rd_q;
   logic [DATA_W-1:0]    rd_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         mdio_o   <= 1'b1;
         mdio_oe  <= 1'b0;
         rdata    <= '0;
         frame_sh <= '0;
         idx      <= '0;
         rd_q     <= 1'b0;
         rd_sh    <= '0;
      end else if (abort) begin
         busy    <= 1'b0;
         mdio_oe <= 1'b0;
         idx     <= '0;
      end else if (start && !busy) begin
         busy     <= 1'b1;
         rd_q     <= op_rd;
         idx      <= '0;
         frame_sh <= {{PRE_LEN{1'b1}}, 2'b01, (op_rd ? OP_RD : OP_WR), phy, regn,
                      (op_rd ? 2'b11 : 2'b10), (op_rd ? DATA_W'(0) : wdata)};
      end else if (busy) begin
         if (tick_low) begin
            if (idx == IDX_W'(FRAME_LEN)) begin
               busy    <= 1'b0;
               mdio_oe <= 1'b0;
               if (rd_q) rdata <= rd_sh;
            end else begin
               mdio_o   <= frame_sh[FRAME_LEN-1];
               frame_sh <= {frame_sh[FRAME_LEN-2:0], 1'b1};
               mdio_oe  <= !rd_q || (idx < IDX_W'(DRIVE_LEN));
               idx      <= idx + 1'b1;
            end
         end
         if (tick_rise && rd_q && (idx > IDX_W'(SAMP_FROM)))
            rd_sh <= {rd_sh[DATA_W-2:0], mdio_i};
      end
   end

   // R5: line released from the turnaround onward
   a_r5_released: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rd_q && (idx > IDX_W'(DRIVE_LEN))) |-> !mdio_oe);
   // R4: a write drives every slot
   a_r4_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_q && (idx != '0)) |-> mdio_oe);
   a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdio_oe);
endmodule

// File: rtl/mdio_host.sv
module mdio_host
   import mdio_host_pkg::*;
#(
   parameter int SYS_CLK_HZ = 100_000_000,
   parameter int MDC_MAX_HZ = 12_500_000,
   parameter int PRE_LEN    = 32,
   parameter int RA_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              mdc,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe
);
   generate
      if (PRE_LEN < 1 || PRE_LEN > 32) begin : g_bad_pre
         $error("PRE_LEN must lie in 1..32");
      end
      if (MDC_MAX_HZ <= 0 || SYS_CLK_HZ <= 0) begin : g_bad_clk
         $error("clock rates must be positive");
      end
      if (RA_W < 3) begin : g_bad_ra
         $error("RA_W must be at least 3");
      end
   endgenerate

   localparam logic [DSEL_W-1:0] SEL_RST = pick_sel(SYS_CLK_HZ / MDC_MAX_HZ);
   localparam logic [RA_W-1:0] A_CFG = RA_W'(0);
   localparam logic [RA_W-1:0] A_ADR = RA_W'(1);
   localparam logic [RA_W-1:0] A_WD  = RA_W'(2);
   localparam logic [RA_W-1:0] A_CMD = RA_W'(3);
   localparam logic [RA_W-1:0] A_RD  = RA_W'(4);
   localparam logic [RA_W-1:0] A_ST  = RA_W'(5);

   logic [DSEL_W-1:0] sel_q;
   logic              mrst_q;
   logic [PHY_W-1:0]  phy_q;
   logic [REGN_W-1:0] regn_q;
   logic [DATA_W-1:0] wd_q;
   logic              rdbit_q;
   logic [DIVC_W-1:0] div_run_q;
   logic              busy, start_wr, start_rd, tick_low, tick_rise;
   logic [DATA_W-1:0] rd_val;

   assign start_wr = reg_we && (reg_addr == A_WD) && !busy && !mrst_q;
   assign start_rd = reg_we && (reg_addr == A_CMD) && reg_wdata[0] && !rdbit_q
                     && !busy && !mrst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= SEL_RST;
         mrst_q    <= 1'b0;
         phy_q     <= '0;
         regn_q    <= '0;
         wd_q      <= '0;
         rdbit_q   <= 1'b0;
         div_run_q <= div_of(SEL_RST);
      end else begin
         if (start_wr || start_rd) div_run_q <= div_of(sel_q);
         if (reg_we) begin
            case (reg_addr)
               A_CFG: begin
                  sel_q  <= reg_wdata[DSEL_W-1:0];
                  mrst_q <= reg_wdata[15];
               end
               A_ADR: begin
                  phy_q  <= reg_wdata[8 +: PHY_W];
                  regn_q <= reg_wdata[0 +: REGN_W];
               end
               A_WD:    if (!busy) wd_q <= reg_wdata;
               A_CMD:   if (!busy) rdbit_q <= reg_wdata[0];
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (reg_addr)
         A_CFG:   reg_rdata = {mrst_q, 12'h000, sel_q};
         A_ADR:   reg_rdata = {3'b000, phy_q, 3'b000, regn_q};
         A_WD:    reg_rdata = wd_q;
         A_CMD:   reg_rdata = {15'h0000, rdbit_q};
         A_RD:    reg_rdata = rd_val;
         A_ST:    reg_rdata = {15'h0000, busy};
         default: reg_rdata = '0;
      endcase
   end

   mdio_host_clk #(.CNT_W(DIVC_W)) u_clk (
      .clk(clk), .rst_n(rst_n), .run(busy && !mrst_q), .div(div_run_q),
      .tick_low(tick_low), .tick_rise(tick_rise), .mdc(mdc));

   mdio_host_eng #(.PRE_LEN(PRE_LEN)) u_eng (
      .clk(clk), .rst_n(rst_n), .abort(mrst_q), .start(start_wr || start_rd),
      .op_rd(start_rd), .phy(phy_q), .regn(regn_q), .wdata(reg_wdata),
      .tick_low(tick_low), .tick_rise(tick_rise), .mdio_i(mdio_i),
      .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .rdata(rd_val));

   a_r7_change_low: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc);
   a_r8_held_idle: assert property (@(posedge clk) disable iff (!rst_n)
      mrst_q |=> (!busy && !mdio_oe));
   a_r9_wd_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we && (reg_addr == A_WD)) |=> $stable(wd_q));
   a_r9_cmd_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && reg_we && (reg_addr == A_CMD)) |=> $stable(rdbit_q));
endmodule

// File: tb/sim_mdio_host.sv
module sim_mdio_host;
   localparam int SYS = 125_000_000;
   localparam int MAXF = 11_000_000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'h0;
   logic [15:0] reg_rdata;
   logic mdc, mdio_o, mdio_oe;
   logic mdio_i = 1'b1;

   always #4 clk = ~clk;

   mdio_host #(.SYS_CLK_HZ(SYS), .MDC_MAX_HZ(MAXF), .PRE_LEN(32), .RA_W(3)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe));

   int n_chk = 0, n_err = 0;
   bit done = 0;

   // bench PHY model
   logic [63:0] cap = '0, oecap = '0;
   logic [15:0] resp = 16'h0;
   int   rises = 0;
   logic arm = 1'b0;
   always @(posedge mdc or posedge arm) begin
      if (arm) begin
         rises = 0;
         mdio_i <= 1'b1;
      end else begin
         cap   <= {cap[62:0], mdio_o};
         oecap <= {oecap[62:0], mdio_oe};
         rises = rises + 1;
         if (rises >= 48 && rises <= 63) mdio_i <= resp[63-rises];
         else mdio_i <= 1'b1;
      end
   end

   time last_rise = 0, per_ns = 0, hi_ns = 0;
   always @(posedge mdc) begin
      per_ns = $time - last_rise;
      last_rise = $time;
   end
   always @(negedge mdc) hi_ns = $time - last_rise;

   int viol = 0;
   logic prev_o = 1'b1, prev_oe = 1'b0;
   always @(negedge clk) begin
      if (rst_n && ((mdio_o !== prev_o) || (mdio_oe !== prev_oe)) && mdc) viol++;
      prev_o = mdio_o;
      prev_oe = mdio_oe;
   end

   function automatic int divv(input int s);
      case (s)
         0: return 4; 1: return 6; 2: return 8; 3: return 10;
         4: return 14; 5: return 20; default: return 28;
      endcase
   endfunction

   function automatic int exp_sel(input int ratio);
      for (int i = 0; i < 7; i++) if (divv(i) >= ratio) return i;
      return 6;
   endfunction

   function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                            input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, 2'b01, p, r, 2'b10, d};
   endfunction

   function automatic logic [45:0] rd_head(input logic [4:0] p, input logic [4:0] r);
      return {32'hFFFF_FFFF, 2'b01, 2'b10, p, r};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic arm_phy();
      arm = 1'b1; #1; arm = 1'b0;
   endtask

   task automatic wait_idle(input string req);
      logic [15:0] st;
      bit ok = 0;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         reg_rd(3'd5, st);
         if (st[0] == 1'b0) begin ok = 1; break; end
      end
      chk({req, " busy clears"}, {63'd0, ok}, 64'd1);
   endtask

   task automatic do_write(input int s, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] d);
      logic [15:0] st;
      reg_wr(3'd0, 16'(s));
      reg_wr(3'd1, {3'b000, p, 3'b000, r});
      arm_phy();
      reg_wr(3'd2, d);
      reg_rd(3'd5, st);
      chk("R6 busy after write start", {48'd0, st}, 64'd1);
      wait_idle("R6");
      chk("R4 write frame", cap, wr_frame(p, r, d));
      chk("R4 write drive", oecap, {64{1'b1}});
      chk("R3 mdc period", 64'(per_ns), 64'(divv(s) * 8));
      chk("R3 mdc high", 64'(hi_ns), 64'(divv(s) * 4));
   endtask

   task automatic do_read(input int s, input logic [4:0] p, input logic [4:0] r,
                          input logic [15:0] v);
      logic [15:0] st, rv;
      reg_wr(3'd0, 16'(s));
      reg_wr(3'd1, {3'b000, p, 3'b000, r});
      resp = v;
      arm_phy();
      reg_wr(3'd3, 16'h0001);
      reg_rd(3'd5, st);
      chk("R6 busy after read start", {48'd0, st}, 64'd1);
      wait_idle("R6");
      reg_rd(3'd4, rv);
      chk("R5 read data", {48'd0, rv}, {48'd0, v});
      chk("R5 read header", {18'd0, cap[63:18]}, {18'd0, rd_head(p, r)});
      chk("R5 read release", oecap, {{46{1'b1}}, 18'd0});
      repeat (3 * divv(s)) @(negedge clk);
      reg_rd(3'd5, st);
      chk("R6 held read bit starts nothing", {48'd0, st}, 64'd0);
      reg_wr(3'd3, 16'h0000);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_rd(3'd5, v); chk("R1 status", {48'd0, v}, 64'd0);
      chk("R1 mdc", {63'd0, mdc}, 64'd0);
      chk("R1 oe", {63'd0, mdio_oe}, 64'd0);
      reg_rd(3'd4, v); chk("R1 read data", {48'd0, v}, 64'd0);
      // R2 reset divider select
      reg_rd(3'd0, v); chk("R2 cfg reset", {48'd0, v}, 64'(exp_sel(SYS / MAXF)));
      // R10 read-data ignores writes, unused bits zero
      reg_wr(3'd4, 16'hFFFF);
      reg_rd(3'd4, v); chk("R10 rdata ignores write", {48'd0, v}, 64'd0);
      reg_wr(3'd1, 16'hFFFF);
      reg_rd(3'd1, v); chk("R10 addr unused bits", {48'd0, v}, 64'h1F1F);
      reg_rd(3'd6, v); chk("R10 unmapped reads zero", {48'd0, v}, 64'd0);

      // directed corners
      do_write(0, 5'd31, 5'd31, 16'hFFFF);
      do_write(7, 5'd0, 5'd0, 16'h0000);
      do_read(0, 5'd1, 5'd2, 16'hA5C3);
      do_read(6, 5'd31, 5'd0, 16'h0001);

      // R9 writes while busy are ignored
      reg_wr(3'd0, 16'h0002);
      reg_wr(3'd1, {3'b000, 5'd5, 3'b000, 5'd9});
      arm_phy();
      reg_wr(3'd2, 16'h1234);
      reg_wr(3'd2, 16'hBEEF);
      reg_wr(3'd3, 16'h0001);
      wait_idle("R9");
      chk("R9 frame keeps first data", cap, wr_frame(5'd5, 5'd9, 16'h1234));
      reg_rd(3'd2, v); chk("R9 wdata unchanged", {48'd0, v}, 64'h1234);
      reg_rd(3'd3, v); chk("R9 cmd unchanged", {48'd0, v}, 64'd0);
      repeat (40) @(negedge clk);
      reg_rd(3'd5, v); chk("R9 no second frame", {48'd0, v}, 64'd0);

      // R8 management reset aborts and holds idle
      reg_wr(3'd0, 16'h0006);
      arm_phy();
      reg_wr(3'd2, 16'h5555);
      repeat (301) @(negedge clk);
      reg_wr(3'd0, 16'h8006);
      @(negedge clk);
      reg_rd(3'd5, v); chk("R8 abort busy", {48'd0, v}, 64'd0);
      chk("R8 abort mdc", {63'd0, mdc}, 64'd0);
      chk("R8 abort oe", {63'd0, mdio_oe}, 64'd0);
      reg_wr(3'd2, 16'h7777);
      reg_wr(3'd3, 16'h0001);
      repeat (5) @(negedge clk);
      reg_rd(3'd5, v); chk("R8 no start in reset", {48'd0, v}, 64'd0);
      reg_wr(3'd3, 16'h0000);
      reg_wr(3'd0, 16'h0001);
      repeat (5) @(negedge clk);
      reg_rd(3'd5, v); chk("R8 release starts nothing", {48'd0, v}, 64'd0);
      do_write(1, 5'd3, 5'd4, 16'h0F0F);

      // random mix
      for (int k = 0; k < 16; k++) begin
         int s = $urandom_range(0, 7);
         logic [4:0] p = 5'($urandom);
         logic [4:0] r = 5'($urandom);
         logic [15:0] d = 16'($urandom);
         if ($urandom_range(0, 1) == 0) do_write(s, p, r, d);
         else do_read(s, p, r, d);
      end

      chk("R7 line changes only while mdc low", 64'(viol), 64'd0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule